// File: doc/BRIEF.md
# Registered Read-Only Lookup Memory

A single-port read-only memory whose words are produced by a fixed, synthesizable function of the address, so no initialization file is needed. The address is always captured in an input register. The data output may pass through a second register or come straight from the array. Both choices are made at build time.

The block runs from one clock, or from two: an input clock for the address register and an output clock for the data register. Enables can be shared or split per clock. An active-low stall input freezes the latched address without touching the data register. An active-low asynchronous clear zeroes every register. Typical uses are constant tables, coefficient lookups and test-pattern sources.

Top module: `reg_rom`

## Requirements
- R1: The word at address `a` has bit i equal to `a[i mod ADDR_W] ^ KEY[i]`. With the defaults (ADDR_W=8, DATA_W=16, KEY=16'hA5C3) this is `{a,a} ^ 16'hA5C3`.
- R2: With OUT_REG=1, an address captured at one output-register edge appears on `q_o` at the next enabled output edge. In single-clock mode that makes the latency two clock edges.
- R3: The address register loads `addr_i` on an input-clock edge when `en_in_i`=1 and `stall_ni`=1.
- R4: While `stall_ni`=0, the address register keeps its value whatever `addr_i` and `en_in_i` do.
- R5: While `en_in_i`=0, the address register keeps its value.
- R6: With SPLIT_EN=1, the output register loads only on edges where `en_out_i`=1; otherwise `q_o` holds.
- R7: `rst_ni`=0 clears the address register and the output register at once, without a clock edge. Normal loading resumes on the first edge after release.
- R8: With SPLIT_EN=0, `en_in_i` also gates the output register and `en_out_i` has no effect.
- R9: With DUAL_CLK=1, the output register is clocked by `clk_out_i`. With DUAL_CLK=0, `clk_in_i` clocks every register and `clk_out_i` has no effect.
- R10: With OUT_REG=0, `q_o` is the word of the address register, one input edge after the address is presented. During a clear, `q_o` shows the word of address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in_i | input | 1 | Clock of the address register (of all registers in single-clock mode) |
| clk_out_i | input | 1 | Clock of the output register in dual-clock mode |
| rst_ni | input | 1 | Active-low asynchronous clear of all registers |
| en_in_i | input | 1 | Enable of the input side; of everything when enables are shared |
| en_out_i | input | 1 | Enable of the output register when enables are split |
| stall_ni | input | 1 | Active-low address hold |
| addr_i | input | ADDR_W | Read address |
| q_o | output | DATA_W | Read data |

## Verification
With the output register in single-clock mode, a new address shows on `q_o` two input edges after it is driven. Without the output register it shows after one edge, and a clear acts within the same time step. Inputs change on the falling edge, and every result is sampled on a falling edge after exactly the number of rising edges its path contains. Intermediate samples confirm that the value has not arrived early. In the two-clock setup the address is held steady for two input edges, and the output is then sampled one time unit after an output-clock edge. Because that sampling point never coincides with an input edge, every result is read only from settled registers.

// File: rtl/rom_pkg.sv
package rom_pkg;
  localparam logic [63:0] DEFAULT_KEY = 64'h5A3C_96E1_0F7B_A5C3;
  localparam int unsigned MIN_DEPTH = 32;
  localparam int unsigned MAX_DEPTH = 4096;

  function automatic bit legal_depth(int unsigned d);
    return (d >= MIN_DEPTH) && (d <= MAX_DEPTH) && ((d & (d - 1)) == 0);
  endfunction
endpackage

// File: rtl/rom_addr_reg.sv
module rom_addr_reg #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stall_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_o <= '0;
    else if (en_i && stall_ni) addr_o <= addr_i;
  end

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stall_ni) |=> (addr_o == $past(addr_i)));
  a_r4_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_ni |=> $stable(addr_o));
  a_r5_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(addr_o));
  a_r7_addr_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0));
endmodule

// File: rtl/rom_array.sv
module rom_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  // word bit i = address bit (i mod ADDR_W) flipped by key bit i
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data_o[i] = addr_i[i % ADDR_W] ^ KEY[i];
  end
endmodule

// File: rtl/rom_out_stage.sv
module rom_out_stage #(
  parameter int unsigned DATA_W = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (en_i) q_o <= d_i;
    end

    a_r6_q_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(q_o));
    a_r2_q_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> (q_o == $past(d_i)));
    a_r7_q_clear: assert property (@(posedge clk_i)
      !rst_ni |-> (q_o == '0));
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/reg_rom.sv
module reg_rom #(
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned DATA_W   = 16,
  parameter bit          DUAL_CLK = 1'b1,
  parameter bit          SPLIT_EN = 1'b1,
  parameter bit          OUT_REG  = 1'b1,
  parameter logic [DATA_W-1:0] KEY = rom_pkg::DEFAULT_KEY[DATA_W-1:0],
  localparam int unsigned ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk_in_i,
  input  logic              clk_out_i,
  input  logic              rst_ni,
  input  logic              en_in_i,
  input  logic              en_out_i,
  input  logic              stall_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] q_o
);
  logic              clk_q;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word;

  initial a_depth_legal: assert (rom_pkg::legal_depth(DEPTH));

  if (DUAL_CLK) begin : g_dual_clk
    assign clk_q = clk_out_i;
  end else begin : g_single_clk
    assign clk_q = clk_in_i;
  end

  if (SPLIT_EN) begin : g_split_en
    assign en_q = en_out_i;
  end else begin : g_shared_en
    assign en_q = en_in_i;
  end

  rom_addr_reg #(.ADDR_W(ADDR_W)) i_addr_reg (
    .clk_i    (clk_in_i),
    .rst_ni   (rst_ni),
    .en_i     (en_in_i),
    .stall_ni (stall_ni),
    .addr_i   (addr_i),
    .addr_o   (addr_q)
  );

  rom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) i_array (
    .addr_i (addr_q),
    .data_o (word)
  );

  rom_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) i_out (
    .clk_i  (clk_q),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .d_i    (word),
    .q_o    (q_o)
  );
endmodule

// File: tb/test_reg_rom.sv
module test_reg_rom;
  localparam int CLK_PERIOD = 10;
  localparam int OUT_PERIOD = 14;
  localparam logic [15:0] KEY = 16'hA5C3;
  localparam int NVEC = 8;
  localparam logic [7:0]  VEC_A [NVEC] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hC3};
  localparam logic [15:0] VEC_Q [NVEC] = '{16'hA5C3, 16'h5A3C, 16'hFF99, 16'h0066,
                                           16'hA4C2, 16'h2543, 16'h99FF, 16'h6600};

  logic clk = 1'b0, clk_out = 1'b0;
  logic rst_ni = 1'b1;
  logic en = 1'b0, stall_n = 1'b1;
  logic [7:0] addr = '0;
  logic en_b = 1'b1, eno_b = 1'b0;
  logic [7:0] addr_b = '0;
  logic [15:0] q_a, q_b, q_c;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(OUT_PERIOD/2) clk_out = ~clk_out;

  // single clock, shared enable, registered output; unused clock/enable tied low
  reg_rom #(.DUAL_CLK(1'b0), .SPLIT_EN(1'b0), .OUT_REG(1'b1), .KEY(KEY)) i_reg_rom (
    .clk_in_i(clk), .clk_out_i(1'b0), .rst_ni(rst_ni), .en_in_i(en), .en_out_i(1'b0),
    .stall_ni(stall_n), .addr_i(addr), .q_o(q_a));

  reg_rom #(.DUAL_CLK(1'b1), .SPLIT_EN(1'b1), .OUT_REG(1'b1), .KEY(KEY)) i_reg_rom_dual (
    .clk_in_i(clk), .clk_out_i(clk_out), .rst_ni(rst_ni), .en_in_i(en_b), .en_out_i(eno_b),
    .stall_ni(1'b1), .addr_i(addr_b), .q_o(q_b));

  reg_rom #(.DUAL_CLK(1'b0), .SPLIT_EN(1'b0), .OUT_REG(1'b0), .KEY(KEY)) i_reg_rom_comb (
    .clk_in_i(clk), .clk_out_i(1'b0), .rst_ni(rst_ni), .en_in_i(en), .en_out_i(1'b0),
    .stall_ni(stall_n), .addr_i(addr), .q_o(q_c));

  function automatic logic [15:0] word_of(logic [7:0] a);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[i] = a[i % 8] ^ KEY[i];
    return w;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic out_edge(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_out);
      #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    tick(2);
    chk("R7 reset q reg", q_a, 16'h0000);
    chk("R10 reset word0", q_c, 16'hA5C3);
    chk("R7 reset dual q", q_b, 16'h0000);
    rst_ni = 1'b1; en = 1'b1;
    tick(2);

    // vector walk: C one edge, A two edges
    for (int i = 0; i < NVEC; i++) begin
      addr = VEC_A[i];
      tick();
      chk("R10 one-edge latency", q_c, VEC_Q[i]);
      if (i > 0) chk("R2 not early", q_a, VEC_Q[i-1]);
      tick();
      chk("R2 two-edge latency", q_a, VEC_Q[i]);
    end

    // full sweep of contents
    for (int a = 0; a < 256; a++) begin
      addr = 8'(a);
      tick();
      chk("R1 contents", q_c, word_of(8'(a)));
    end

    // stall
    addr = 8'h5A; tick(2);
    stall_n = 1'b0; addr = 8'hA5; tick(3);
    chk("R4 stall holds addr (A)", q_a, 16'hFF99);
    chk("R4 stall holds addr (C)", q_c, 16'hFF99);
    stall_n = 1'b1; tick();
    chk("R3 load after stall", q_c, 16'h0066);
    tick();
    chk("R3 load after stall (A)", q_a, 16'h0066);

    // input enable low
    en = 1'b0; addr = 8'h01; tick(3);
    chk("R5 enable low holds (C)", q_c, 16'h0066);
    chk("R5 enable low holds (A)", q_a, 16'h0066);

    // shared enable gates output register too
    en = 1'b1; tick();
    en = 1'b0; tick(3);
    chk("R8 shared enable freezes q", q_a, 16'h0066);
    chk("R8 address moved", q_c, 16'hA4C2);
    en = 1'b1; tick();
    chk("R8 q resumes with enable", q_a, 16'hA4C2);

    // dual clock, split enables
    addr_b = 8'h3C; tick(2);
    out_edge(3);
    chk("R6 out enable low holds", q_b, 16'h0000);
    eno_b = 1'b1;
    out_edge();
    chk("R9 output clock loads", q_b, 16'h99FF);
    eno_b = 1'b0;
    @(negedge clk); addr_b = 8'hC3; tick(2);
    out_edge(2);
    chk("R6 hold with new address", q_b, 16'h99FF);
    eno_b = 1'b1;
    out_edge();
    chk("R9 output clock loads again", q_b, 16'h6600);

    // asynchronous clear mid-run
    @(negedge clk); #2 rst_ni = 1'b0;
    #1;
    chk("R7 clear q immediate", q_a, 16'h0000);
    chk("R7 clear addr immediate", q_c, 16'hA5C3);
    chk("R7 clear dual immediate", q_b, 16'h0000);
    @(negedge clk); addr = 8'h80; tick();
    chk("R7 held while clear", q_a, 16'h0000);
    rst_ni = 1'b1;
    tick();
    chk("R7 resume first edge (C)", q_c, 16'h2543);
    tick();
    chk("R7 resume (A)", q_a, 16'h2543);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule